// File: doc/BRIEF.md
# Indexed Window Register Port

This block lets software reach a bank of eight configuration words and a sixteen-entry result buffer through just two bus registers. The first is a pointer register. It holds a space-select bit and a four-bit index. The second is a data window. Each access to the window reaches the word that the pointer currently names. The index then steps forward by one, so software can stream through a run of words without rewriting the pointer.

The select bit picks the space. With the bit set, the window reaches the configuration bank, which can be read and written, and only the low three index bits take part. With the bit clear, the window reaches the result buffer, which software can only read. The conversion engine fills the buffer through its own write ports. If the engine writes an entry in the same cycle that software reads it, the new value is forwarded to the read.

Top module: `ixp_window_port`

## Requirements
- R1: After a synchronous active-high reset, the select bit, the index, all configuration words and all buffer entries are 0. A read of the pointer register returns 0.
- R2: The pointer register sits at bus address 0. Bit 4 is the select bit and bits 3:0 are the index. A write stores both fields, a read returns them, and all other bits read as 0. When the read strobe is low, the read data is 0.
- R3: Any window access at bus address 1 advances the index by one on the next clock edge. The access may be a read, a write, or both strobes in the same cycle, and it counts once. The index wraps from 15 to 0. Read data comes from the index as it stood before the increment.
- R4: With the select bit at 1, the window addresses configuration word index[2:0]. A write stores the 16-bit write data there and a read returns it, so index values 8..15 alias words 0..7.
- R5: With the select bit at 0, a window read returns buffer entry index[3:0]. A window write is discarded and changes no configuration word and no buffer entry, but the index still advances.
- R6: When an engine port's valid bit is high, that port stores its data into the buffer entry it names, on the clock edge. If several ports write the same entry together, the highest-numbered port wins.
- R7: A window read of a buffer entry that an engine port writes in the same cycle returns the newly written value, using the winning port's data.
- R8: A cycle with no window access and no pointer write leaves the index unchanged. Reading the pointer register does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 1 | 0 selects the pointer register, 1 selects the data window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; valid in the same cycle as bus_rd |
| eng_valid | input | NUM_ENG | Per-port engine write enable |
| eng_idx | input | 4*NUM_ENG | Per-port buffer entry, port p in bits 4p+3:4p |
| eng_data | input | 16*NUM_ENG | Per-port write data, port p in bits 16p+15:16p |

## Verification
The bench builds the block with its default sizes: two engine ports, eight configuration words and sixteen buffer entries. At these sizes every index value, both select settings and every port-priority case can be swept in full, and each expected value is computed from the loop counter. Sixteen consecutive configuration writes cover the alias of index values 8..15 onto words 0..7 and the wrap from 15 to 0. Two engine ports are the fewest that can show the same-entry priority and the forwarding of the winning port's data to a same-cycle read.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
    localparam int DATA_W  = 16;
    localparam int CFG_N   = 8;
    localparam int BUF_N   = 16;
    localparam int IDX_W   = $clog2(BUF_N);
    localparam int CFG_AW  = $clog2(CFG_N);
    localparam int SEL_BIT = IDX_W;

    localparam logic PTR_ADDR = 1'b0;
    localparam logic WIN_ADDR = 1'b1;

    typedef struct packed {
        logic             sel;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    function automatic logic [DATA_W-1:0] ptr_to_word(input ptr_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SEL_BIT]     = p.sel;
        w[IDX_W-1:0]   = p.idx;
        return w;
    endfunction

    function automatic ptr_t word_to_ptr(input logic [DATA_W-1:0] w);
        ptr_t p;
        p.sel = w[SEL_BIT];
        p.idx = w[IDX_W-1:0];
        return p;
    endfunction
endpackage

// File: rtl/ixp_ptr.sv
module ixp_ptr
    import ixp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              step,
    output ptr_t              ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ld) begin
            ptr <= word_to_ptr(ld_data);
        end else if (step) begin
            ptr.idx <= ptr.idx + 1'b1;
        end
    end

    // R3: every window access advances the index by one, wrapping at the top
    a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
        (step && !ld) |=> (ptr.idx == IDX_W'($past(ptr.idx) + 1'b1)));

    // R8: an idle cycle holds the pointer
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld) |=> $stable(ptr));

    // R2: a pointer write lands both fields
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> (ptr.sel == $past(ld_data[SEL_BIT])) && (ptr.idx == $past(ld_data[IDX_W-1:0])));
endmodule

// File: rtl/ixp_cfg_bank.sv
module ixp_cfg_bank
    import ixp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [CFG_AW-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [CFG_N-1:0][DATA_W-1:0] regs
);
    for (genvar g = 0; g < CFG_N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (waddr == CFG_AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    // R4: a configuration write reaches the addressed word
    a_r4_cfg_store: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ixp_result_buf.sv
module ixp_result_buf
    import ixp_pkg::*;
#(
    parameter int NUM_ENG = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_ENG-1:0]        eng_valid,
    input  logic [NUM_ENG*IDX_W-1:0]  eng_idx,
    input  logic [NUM_ENG*DATA_W-1:0] eng_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int TOP = NUM_ENG - 1;

    logic [BUF_N-1:0][DATA_W-1:0] mem;
    logic [BUF_N-1:0][DATA_W-1:0] wr_val;
    logic [BUF_N-1:0]             hit;

    // Per-entry winner: later (higher-numbered) ports override earlier ones
    always_comb begin
        hit    = '0;
        wr_val = mem;
        for (int p = 0; p < NUM_ENG; p++) begin
            if (eng_valid[p]) begin
                hit[eng_idx[p*IDX_W +: IDX_W]]    = 1'b1;
                wr_val[eng_idx[p*IDX_W +: IDX_W]] = eng_data[p*DATA_W +: DATA_W];
            end
        end
    end

    for (genvar e = 0; e < BUF_N; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (hit[e]) begin
                mem[e] <= wr_val[e];
            end
        end
    end

    // Forward same-cycle engine data to the software read
    assign rd_data = hit[rd_idx] ? wr_val[rd_idx] : mem[rd_idx];

    // R6: the highest-numbered port always lands its data
    a_r6_top_port_wins: assert property (@(posedge clk) disable iff (rst)
        eng_valid[TOP] |=> (mem[$past(eng_idx[TOP*IDX_W +: IDX_W])] ==
                            $past(eng_data[TOP*DATA_W +: DATA_W])));

    // R5/R6: with no engine write, the buffer holds
    a_r5_buf_hold: assert property (@(posedge clk) disable iff (rst)
        (eng_valid == '0) |=> $stable(mem));
endmodule

// File: rtl/ixp_window_port.sv
module ixp_window_port
    import ixp_pkg::*;
#(
    parameter int NUM_ENG = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_ENG-1:0]        eng_valid,
    input  logic [NUM_ENG*IDX_W-1:0]  eng_idx,
    input  logic [NUM_ENG*DATA_W-1:0] eng_data
);
    ptr_t                         ptr;
    logic                         win_acc;
    logic                         ptr_ld;
    logic                         cfg_we;
    logic [CFG_N-1:0][DATA_W-1:0] cfg_regs;
    logic [DATA_W-1:0]            buf_rd;

    assign win_acc = (bus_addr == WIN_ADDR) && (bus_wr || bus_rd);
    assign ptr_ld  = (bus_addr == PTR_ADDR) && bus_wr;
    assign cfg_we  = (bus_addr == WIN_ADDR) && bus_wr && ptr.sel;

    ixp_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld      (ptr_ld),
        .ld_data (bus_wdata),
        .step    (win_acc),
        .ptr     (ptr)
    );

    ixp_cfg_bank u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (ptr.idx[CFG_AW-1:0]),
        .wdata (bus_wdata),
        .regs  (cfg_regs)
    );

    ixp_result_buf #(.NUM_ENG(NUM_ENG)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .eng_valid (eng_valid),
        .eng_idx   (eng_idx),
        .eng_data  (eng_data),
        .rd_idx    (ptr.idx),
        .rd_data   (buf_rd)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == PTR_ADDR) begin
                bus_rdata = ptr_to_word(ptr);
            end else if (ptr.sel) begin
                bus_rdata = cfg_regs[ptr.idx[CFG_AW-1:0]];
            end else begin
                bus_rdata = buf_rd;
            end
        end
    end

    // R5: a window write in buffer mode leaves every configuration word alone
    a_r5_discard: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == WIN_ADDR) && !ptr.sel) |=> $stable(cfg_regs));

    // R2: with the read strobe low the read bus stays at zero
    a_r2_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/tb_ixp_window_port.sv
module tb_ixp_window_port;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NE-1:0]    eng_valid = '0;
    logic [NE*4-1:0]  eng_idx = '0;
    logic [NE*16-1:0] eng_data = '0;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    ixp_window_port #(.NUM_ENG(NE)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_valid(eng_valid), .eng_idx(eng_idx), .eng_data(eng_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle with optional engine writes; rdata sampled before the edge
    task automatic cyc(input logic a, input logic w, input logic r, input logic [15:0] wd,
                       input logic [NE-1:0] ev, input logic [NE*4-1:0] ei,
                       input logic [NE*16-1:0] ed, output logic [15:0] rd);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = wd;
        eng_valid = ev; eng_idx = ei; eng_data = ed;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; eng_valid = '0;
    endtask

    task automatic bw(input logic a, input logic [15:0] wd);
        logic [15:0] d;
        cyc(a, 1'b1, 1'b0, wd, '0, '0, '0, d);
    endtask

    task automatic br(input logic a, output logic [15:0] rd);
        cyc(a, 1'b0, 1'b1, 16'h0, '0, '0, '0, rd);
    endtask

    function automatic logic [15:0] cfgval(input int i);
        return 16'(16'h1000 + i * 16'h0111);
    endfunction

    function automatic logic [15:0] bufval(input int i);
        return 16'(16'hA000 ^ (i * 16'h0101));
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        br(1'b0, got); chk("R1 pointer", got, 16'h0000);
        br(1'b1, got); chk("R1 buffer entry 0", got, 16'h0000);
        bw(1'b0, 16'h0010);
        for (int k = 0; k < 8; k++) begin
            br(1'b1, got); chk("R1 cfg word", got, 16'h0000);
        end

        // R2: field layout, other bits read zero; R8 pointer read does not step
        bw(1'b0, 16'hFFF5);
        br(1'b0, got); chk("R2 pointer readback", got, 16'h0015);
        br(1'b0, got); chk("R8 pointer read no step", got, 16'h0015);
        cyc(1'b0, 1'b0, 1'b0, 16'h0, '0, '0, '0, got);
        chk("R2 idle rdata zero", got, 16'h0000);
        br(1'b0, got); chk("R8 idle hold", got, 16'h0015);

        // R4/R3: 16 config writes alias onto 8 words and wrap the index
        bw(1'b0, 16'h0010);
        for (int i = 0; i < 16; i++) bw(1'b1, cfgval(i));
        br(1'b0, got); chk("R3 wrap after 16 steps", got, 16'h0010);
        for (int k = 0; k < 8; k++) begin
            br(1'b1, got); chk("R4 cfg alias readback", got, cfgval(8 + k));
        end
        // R3: combined read+write counts once; read shows pre-write value
        bw(1'b0, 16'h0012);
        cyc(1'b1, 1'b1, 1'b1, 16'hBEEF, '0, '0, '0, got);
        chk("R3 rd+wr pre value", got, cfgval(10));
        br(1'b0, got); chk("R3 rd+wr single step", got, 16'h0013);
        bw(1'b0, 16'h001A);
        br(1'b1, got); chk("R4 alias idx10 -> word2", got, 16'hBEEF);

        // R6: fill buffer alternating engine ports
        for (int i = 0; i < 16; i++) begin
            logic [NE-1:0] ev;
            logic [NE*4-1:0] ei;
            logic [NE*16-1:0] ed;
            ev = (i % 2 == 0) ? 2'b01 : 2'b10;
            ei = {4'(i), 4'(i)};
            ed = {bufval(i), bufval(i)};
            cyc(1'b0, 1'b0, 1'b0, 16'h0, ev, ei, ed, got);
        end
        bw(1'b0, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            br(1'b1, got); chk("R6 buffer sweep", got, bufval(i));
        end
        br(1'b0, got); chk("R3 buffer wrap", got, 16'h0000);

        // R5: discarded window write, index still advances
        bw(1'b0, 16'h0003);
        bw(1'b1, 16'hDEAD);
        br(1'b0, got); chk("R5 index advances", got, 16'h0004);
        bw(1'b0, 16'h0003);
        br(1'b1, got); chk("R5 buffer untouched", got, bufval(3));
        bw(1'b0, 16'h0013);
        br(1'b1, got); chk("R5 cfg untouched", got, cfgval(11));

        // R6: both ports hit entry 5, port 1 wins
        cyc(1'b0, 1'b0, 1'b0, 16'h0, 2'b11, {4'd5, 4'd5}, {16'h2222, 16'h1111}, got);
        bw(1'b0, 16'h0005);
        br(1'b1, got); chk("R6 priority", got, 16'h2222);

        // R7: same-cycle forward, single port and contested
        bw(1'b0, 16'h0009);
        cyc(1'b1, 1'b0, 1'b1, 16'h0, 2'b01, {4'd0, 4'd9}, {16'h0, 16'h5A5A}, got);
        chk("R7 forward", got, 16'h5A5A);
        cyc(1'b1, 1'b0, 1'b1, 16'h0, 2'b11, {4'd10, 4'd10}, {16'h7777, 16'h6666}, got);
        chk("R7 forward winner", got, 16'h7777);
        bw(1'b0, 16'h0009);
        br(1'b1, got); chk("R6 forwarded value stored", got, 16'h5A5A);
        // R7: engine write to another entry does not disturb the read
        cyc(1'b1, 1'b0, 1'b1, 16'h0, 2'b01, {4'd0, 4'd3}, {16'h0, 16'h9999}, got);
        chk("R7 other entry", got, 16'h7777);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule